// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The combiner collects a large vector of level-sensitive interrupt lines and folds them into a smaller set of outputs, one per group of eight sources. Each output goes to a parent interrupt controller. A source numbered `n` on the input vector belongs to group `n / 8` and occupies bit `n % 8` inside that group. Source `n` is therefore input `irq_src[group*8 + bit]`.

Four neighbouring groups share one 32-bit register bank. Group `g` lives in bank `g / 4`, and that bank starts at byte address `(g / 4) * 0x10`. Within the bank, the group owns bits `[8*(g%4)+7 : 8*(g%4)]`.

Each bank has three registers:
- offset 0x0: write a 1 to a bit to enable that source;
- offset 0x4: write a 1 to a bit to disable that source;
- offset 0xC: read-only pending status.

A driver reads the status word of a bank, picks the lowest pending bit and services that source. It can save the enable word by reading offset 0x0 and later restore it by writing the saved value back to offset 0x0.

The register port is a plain single-cycle write strobe with a combinational read.

Top module: `irq_group_combiner`

## Requirements
- R1: After reset every enable bit is 0. Reads of offsets 0x0, 0x4 and 0xC of every bank return 0, and every `irq_out` is 0 whatever `irq_src` holds.
- R2: A write to bank offset 0x0 sets each enable bit whose `reg_wdata` bit is 1. Enable bits written as 0 keep their value.
- R3: A write to bank offset 0x4 clears each enable bit whose `reg_wdata` bit is 1. Enable bits written as 0 keep their value.
- R4: A read of offset 0x0 returns the bank's 32 enable bits, and a read of offset 0x4 returns the same value. Writing that value back to offset 0x0 after the bits were cleared restores them.
- R5: A read of offset 0xC returns, bit by bit, the bank's raw inputs ANDed with its enables. Nothing is latched: a bit falls as soon as its source goes low or it is disabled.
- R6: `irq_out[g]` is the OR of group `g`'s eight status bits. The group's raw inputs are `irq_src[8g+7:8g]`, and its enables are bits `[8*(g%4)+7:8*(g%4)]` of bank `g/4`.
- R7: An enable write takes effect on `irq_out` right after the clock edge that captures the write, and not before that edge.
- R8: Writes to offsets other than 0x0 and 0x4, and writes to banks at or above `ceil(NUM_GROUPS/4)`, change no enable. Reads of such offsets or banks return 0.
- R9: A write that touches one group's bits leaves the enables and the output of every other group unchanged, including the other groups in the same bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte address: bank index in the upper bits, register offset in bits [3:0] |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_src | input | NUM_GROUPS*8 | Raw level interrupt inputs |
| irq_out | output | NUM_GROUPS | One combined request per group |

## Verification
Several input patterns are driven at the group outputs and the status registers:
- sources high with their enable off, then with it on, which separates masking from forwarding;
- a single source at each end of the input vector (bits 0, 7, 24 and 159), which exposes any slip in the group-to-bank bit mapping;
- two groups inside one bank written in turn, which shows whether set and clear writes stay within the group they target;
- a source dropped while still enabled, which tells a level path apart from a latched one.

A timing probe samples the output just before and just after the write edge, and stray writes to unused offsets and to absent banks must leave the readback unchanged.

// File: rtl/irq_combiner_pkg.sv
package irq_combiner_pkg;
    localparam int SRC_PER_GROUP   = 8;
    localparam int GROUPS_PER_BANK = 4;
    localparam int BANK_W          = SRC_PER_GROUP * GROUPS_PER_BANK;

    localparam logic [3:0] OFF_EN_SET = 4'h0;
    localparam logic [3:0] OFF_EN_CLR = 4'h4;
    localparam logic [3:0] OFF_STATUS = 4'hC;

    typedef struct packed {
        logic [BANK_W-1:0] en;
    } bank_state_t;

    // Bits of a bank that belong to groups that exist.
    function automatic logic [BANK_W-1:0] bank_valid_mask(int bank, int ngroups);
        logic [BANK_W-1:0] m;
        m = '0;
        for (int k = 0; k < GROUPS_PER_BANK; k++) begin
            if (bank * GROUPS_PER_BANK + k < ngroups) begin
                m[k*SRC_PER_GROUP +: SRC_PER_GROUP] = '1;
            end
        end
        return m;
    endfunction
endpackage

// File: rtl/irq_bank_regs.sv
module irq_bank_regs
    import irq_combiner_pkg::*;
#(
    parameter logic [BANK_W-1:0] VALID_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] en_q
);
    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_we) begin
            st_d.en = st_d.en | wdata;
        end
        // Clear is applied last, so it dominates a simultaneous set.
        if (clr_we) begin
            st_d.en = st_d.en & ~wdata;
        end
        st_d.en = st_d.en & VALID_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_q = st_q.en;
endmodule

// File: rtl/irq_group_slice.sv
module irq_group_slice #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] raw,
    input  logic [WIDTH-1:0] en,
    output logic [WIDTH-1:0] pend,
    output logic             irq
);
    assign pend = raw & en;
    assign irq  = |pend;
endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
    import irq_combiner_pkg::*;
#(
    parameter int NUM_GROUPS = 20,
    parameter int ADDR_W     = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            reg_wr,
    input  logic [ADDR_W-1:0]               reg_addr,
    input  logic [BANK_W-1:0]               reg_wdata,
    output logic [BANK_W-1:0]               reg_rdata,
    input  logic [NUM_GROUPS*SRC_PER_GROUP-1:0] irq_src,
    output logic [NUM_GROUPS-1:0]           irq_out
);
    localparam int NUM_BANKS  = (NUM_GROUPS + GROUPS_PER_BANK - 1) / GROUPS_PER_BANK;
    localparam int BANK_IDX_W = ADDR_W - 4;

    logic [BANK_IDX_W-1:0] sel_bank;
    logic [3:0]            sel_off;

    logic [NUM_BANKS-1:0][BANK_W-1:0] bank_en;
    logic [NUM_BANKS-1:0][BANK_W-1:0] bank_stat;

    assign sel_bank = reg_addr[ADDR_W-1:4];
    assign sel_off  = reg_addr[3:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [BANK_W-1:0] MASK = bank_valid_mask(b, NUM_GROUPS);
        logic hit, set_we, clr_we;

        assign hit    = reg_wr && (sel_bank == BANK_IDX_W'(b));
        assign set_we = hit && (sel_off == OFF_EN_SET);
        assign clr_we = hit && (sel_off == OFF_EN_CLR);

        irq_bank_regs #(.VALID_MASK(MASK)) u_regs (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (set_we),
            .clr_we (clr_we),
            .wdata  (reg_wdata),
            .en_q   (bank_en[b])
        );

        for (genvar k = 0; k < GROUPS_PER_BANK; k++) begin : g_slot
            localparam int G = b * GROUPS_PER_BANK + k;
            if (G < NUM_GROUPS) begin : g_live
                irq_group_slice #(.WIDTH(SRC_PER_GROUP)) u_slice (
                    .raw  (irq_src[G*SRC_PER_GROUP +: SRC_PER_GROUP]),
                    .en   (bank_en[b][k*SRC_PER_GROUP +: SRC_PER_GROUP]),
                    .pend (bank_stat[b][k*SRC_PER_GROUP +: SRC_PER_GROUP]),
                    .irq  (irq_out[G])
                );
            end else begin : g_absent
                assign bank_stat[b][k*SRC_PER_GROUP +: SRC_PER_GROUP] = '0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (sel_bank == BANK_IDX_W'(b)) begin
                case (sel_off)
                    OFF_EN_SET, OFF_EN_CLR: reg_rdata = bank_en[b];
                    OFF_STATUS:             reg_rdata = bank_stat[b];
                    default:                reg_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/irq_combiner_checker.sv
module irq_combiner_checker
    import irq_combiner_pkg::*;
#(
    parameter int NUM_GROUPS = 20,
    parameter int ADDR_W     = 8,
    parameter int NUM_BANKS  = (NUM_GROUPS + GROUPS_PER_BANK - 1) / GROUPS_PER_BANK
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                reg_wr,
    input logic [ADDR_W-1:0]                   reg_addr,
    input logic [BANK_W-1:0]                   reg_wdata,
    input logic [NUM_GROUPS*SRC_PER_GROUP-1:0] irq_src,
    input logic [NUM_GROUPS-1:0]               irq_out,
    input logic [NUM_BANKS-1:0][BANK_W-1:0]    bank_en
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_out
        // R6: a group cannot request without one of its own sources high
        assert_out_needs_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[g] |-> (irq_src[g*SRC_PER_GROUP +: SRC_PER_GROUP] != '0));
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bk
        localparam logic [BANK_W-1:0] MASK  = bank_valid_mask(b, NUM_GROUPS);
        localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(b * 16);
        localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(b * 16 + 4);

        assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == A_SET) |=>
            ((bank_en[b] & $past(reg_wdata & MASK)) == $past(reg_wdata & MASK)));

        assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == A_CLR) |=> ((bank_en[b] & $past(reg_wdata)) == '0));

        assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(reg_wr && (reg_addr == A_SET || reg_addr == A_CLR)) |=> $stable(bank_en[b]));
    end
endmodule

bind irq_group_combiner irq_combiner_checker #(
    .NUM_GROUPS (NUM_GROUPS),
    .ADDR_W     (ADDR_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_src   (irq_src),
    .irq_out   (irq_out),
    .bank_en   (bank_en)
);

// File: tb/irq_group_combiner_test.sv
module irq_group_combiner_test;
    localparam int NG  = 20;
    localparam int AW  = 8;
    localparam int NB  = (NG + 3) / 4;
    localparam int NS  = NG * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NS-1:0] irq_src = '0;
    logic [NG-1:0] irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [31:0] model_en [NB];

    always #2.5 clk = ~clk;

    irq_group_combiner #(.NUM_GROUPS(NG), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_src(irq_src), .irq_out(irq_out)
    );

    task automatic check(string req, logic [255:0] act, logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a[3:0] == 4'h0 && int'(a[AW-1:4]) < NB) model_en[a[AW-1:4]] |= d;
        if (a[3:0] == 4'h4 && int'(a[AW-1:4]) < NB) model_en[a[AW-1:4]] &= ~d;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    function automatic logic [NG-1:0] model_out();
        logic [NG-1:0] o;
        for (int g = 0; g < NG; g++)
            o[g] = |(irq_src[g*8 +: 8] & model_en[g/4][8*(g%4) +: 8]);
        return o;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        irq_src = '1;
        #0.5;
        check("R1 irq_out after reset", 256'(irq_out), 256'(0));
        for (int b = 0; b < NB; b++) begin
            rd(AW'(b*16), d);      check("R1 en read", 256'(d), 256'(0));
            rd(AW'(b*16 + 4), d);  check("R1 en read clr", 256'(d), 256'(0));
            rd(AW'(b*16 + 12), d); check("R1 status", 256'(d), 256'(0));
        end
        irq_src = '0;
    endtask

    task automatic t_set_clear();
        logic [31:0] d;
        wr(8'h00, 32'h0000_0081);
        rd(8'h00, d); check("R2 set", 256'(d), 256'h81);
        rd(8'h04, d); check("R4 clr offset readback", 256'(d), 256'h81);
        wr(8'h00, 32'h0100_0000);
        rd(8'h00, d); check("R2 zeros keep", 256'(d), 256'h0100_0081);
        wr(8'h04, 32'h0000_0001);
        rd(8'h00, d); check("R3 clear", 256'(d), 256'h0100_0080);
    endtask

    task automatic t_status_out();
        logic [31:0] d;
        irq_src = '0;
        irq_src[0] = 1'b1; irq_src[7] = 1'b1; irq_src[24] = 1'b1; irq_src[9] = 1'b1;
        rd(8'h0C, d); check("R5 status", 256'(d), 256'h0100_0080);
        check("R6 outputs", 256'(irq_out), 256'(model_out()));
        check("R6 group0", 256'(irq_out[0]), 256'(1));
        check("R6 group1 masked", 256'(irq_out[1]), 256'(0));
        irq_src[7] = 1'b0;
        rd(8'h0C, d); check("R5 drop", 256'(d), 256'h0100_0000);
        check("R5 out drop", 256'(irq_out[0]), 256'(0));
        wr(8'h04, 32'h0100_0000);
        rd(8'h0C, d); check("R5 disabled", 256'(d), 256'h0);
        check("R6 group3 off", 256'(irq_out[3]), 256'(0));
        irq_src = '0;
    endtask

    task automatic t_timing();
        irq_src = '0;
        irq_src[42] = 1'b1;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = 32'h0000_0400;
        #1;
        check("R7 before edge", 256'(irq_out[5]), 256'(0));
        @(posedge clk);
        #0.5;
        check("R7 after edge", 256'(irq_out[5]), 256'(1));
        @(negedge clk);
        reg_wr = 1'b0;
        model_en[1] |= 32'h0000_0400;
        check("R7 outputs", 256'(irq_out), 256'(model_out()));
    endtask

    task automatic t_independent();
        logic [31:0] d;
        irq_src = '1;
        wr(8'h10, 32'h00FF_0000);
        wr(8'h14, 32'h0000_FF00);
        rd(8'h10, d); check("R9 bank1 en", 256'(d), 256'h00FF_0000);
        check("R9 outputs", 256'(irq_out), 256'(model_out()));
        check("R9 group6 on", 256'(irq_out[6]), 256'(1));
        check("R9 group4/5/7 off", 256'({irq_out[7], irq_out[5], irq_out[4]}), 256'(0));
        irq_src = '0;
    endtask

    task automatic t_unused();
        logic [31:0] d0, d;
        rd(8'h00, d0);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, d); check("R8 offset 8 reads 0", 256'(d), 256'h0);
        rd(8'h00, d); check("R8 offset 8 write ignored", 256'(d), 256'(d0));
        wr(8'h50, 32'hFFFF_FFFF);
        rd(8'h50, d); check("R8 absent bank", 256'(d), 256'h0);
        rd(8'h40, d); check("R8 bank4 untouched", 256'(d), 256'(model_en[4]));
        rd(8'h02, d); check("R8 odd offset", 256'(d), 256'h0);
    endtask

    task automatic t_last_source();
        irq_src = '0;
        irq_src[NS-1] = 1'b1;
        wr(8'h40, 32'h8000_0000);
        #0.5;
        check("R6 source 159", 256'(irq_out), 256'(1) << (NG-1));
        irq_src = '0;
    endtask

    task automatic t_save_restore();
        logic [31:0] saved, d;
        rd(8'h10, saved);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h10, d); check("R3 all cleared", 256'(d), 256'h0);
        wr(8'h10, saved);
        rd(8'h14, d); check("R4 restore", 256'(d), 256'(saved));
    endtask

    initial begin
        for (int b = 0; b < NB; b++) model_en[b] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_status_out();
        t_timing();
        t_independent();
        t_unused();
        t_last_source();
        t_save_restore();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule